// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Packed Flag Register

This block is the arithmetic core of a small accumulator machine. Each request carries an operation code, a 16-bit first operand and a 16-bit second operand. Byte operations use only the low eight bits of each operand, so the accumulator sits in the low byte of the first operand. Wide operations use the full 16 bits for register-pair arithmetic. The block keeps the machine's flag byte in an internal register. Each accepted operation updates that register according to a rule that depends on the operation.

Requests arrive on a valid/ready channel. Results leave on a second valid/ready channel that has one register stage. A request is accepted on a rising edge where `in_valid` and `in_ready` are both high. The result and the new flag byte become visible right after that edge. While the consumer holds `out_ready` low with a result pending, `in_ready` stays low and the pending result does not change. The flag byte is always visible on `flags_o`. Software can also store it as a group and restore it later, so it can be saved beside the accumulator on a stack.

Top module: `alu8_core`

## Requirements
- R1: ADD (op 0) and ADC (op 1) return A+B (ADC also adds the current C flag) in the low byte of `out_res`, with the upper byte zero. C is the carry out of bit 7 and AC is the carry out of bit 3.
- R2: SUB (op 2), SBB (op 3, which also subtracts C) and CMP (op 7) compute A-B. C is set when a borrow out of bit 7 occurs, and AC is set when a borrow out of bit 3 occurs. SUB and SBB return the difference, while CMP returns A unchanged and sets flags exactly as SUB does.
- R3: For ops 0 to 7, S equals bit 7 of the byte result, Z is set when that byte is zero, and P is set when it holds an even number of ones. For CMP these flags come from the difference.
- R4: AND (op 4), XOR (op 5) and OR (op 6) return the bitwise result and clear both C and AC.
- R5: The flag byte has S at bit 7, Z at bit 6, AC at bit 4, P at bit 2 and C at bit 0. Bit 1 always reads 1, and bits 3 and 5 always read 0.
- R6: WADD (op 10) returns (A16+B16) mod 65536. It sets C to the carry out of bit 15 and leaves every other flag bit unchanged.
- R7: WINC (op 11) and WDEC (op 12) return A16+1 and A16-1 mod 65536, and leave the flag byte unchanged.
- R8: STC (op 8) sets C to 1 and CMC (op 9) inverts C. Neither changes any other flag bit, and both return 0.
- R9: FWR (op 13) loads the flag byte from the low byte of B, with bits 1, 3 and 5 forced to their fixed values, and returns 0. FRD (op 14) returns the flag byte in the low byte of `out_res` and leaves the flags unchanged. NOP (op 15) returns 0 and changes nothing.
- R10: `in_ready` equals `!out_valid || out_ready`. An accepted request raises `out_valid` after the accepting edge. While `out_valid` is high and `out_ready` is low, `out_res` holds its value and `out_valid` stays high.
- R11: After reset, `out_valid` is 0 and the flag byte is 8'h02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_a | input | 16 | First operand (accumulator in low byte) |
| in_b | input | 16 | Second operand |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Consumer takes the result |
| out_res | output | 16 | Result word |
| flags_o | output | 8 | Current flag byte |

## Verification
Both `out_res` and `flags_o` are registered, so each result and its flag byte are due on the first rising edge after the request is accepted. The bench drives inputs on the falling edge and samples both outputs on the next falling edge. For the back-pressure scenario, the bench holds `out_ready` low for several cycles and samples on each falling edge to confirm the pending result has not moved. It then releases `out_ready` and expects the blocked second request to be accepted on that same rising edge. Its result should appear half a cycle later.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADC  = 4'd1,  OP_SUB  = 4'd2,  OP_SBB = 4'd3,
    OP_AND  = 4'd4,  OP_XOR  = 4'd5,  OP_OR   = 4'd6,  OP_CMP = 4'd7,
    OP_STC  = 4'd8,  OP_CMC  = 4'd9,  OP_WADD = 4'd10, OP_WINC = 4'd11,
    OP_WDEC = 4'd12, OP_FWR  = 4'd13, OP_FRD  = 4'd14, OP_NOP = 4'd15
  } alu_op_e;

  localparam int FB_C  = 0;
  localparam int FB_P  = 2;
  localparam int FB_AC = 4;
  localparam int FB_Z  = 6;
  localparam int FB_S  = 7;
  localparam logic [7:0] FIX_MASK = 8'b0010_1010;
  localparam logic [7:0] FIX_VAL  = 8'b0000_0010;

  typedef enum logic [1:0] { WM_ADD = 2'd0, WM_INC = 2'd1, WM_DEC = 2'd2 } wide_mode_e;

  function automatic logic [7:0] pack_flags(input logic s, input logic z,
                                            input logic ac, input logic p,
                                            input logic c);
    logic [7:0] f;
    f = FIX_VAL;
    f[FB_S]  = s;
    f[FB_Z]  = z;
    f[FB_AC] = ac;
    f[FB_P]  = p;
    f[FB_C]  = c;
    return f;
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_flag,
  output logic         ac_flag
);
  localparam int HW = W - NIB;

  logic [W-1:0]   bx;
  logic           ci;
  logic [NIB:0]   lo;
  logic [HW:0]    hi;

  always_comb begin
    bx = sub ? ~b : b;
    ci = sub ? ~cin : cin;
    lo = {1'b0, a[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, ci};
    hi = {1'b0, a[W-1:NIB]} + {1'b0, bx[W-1:NIB]} + {{HW{1'b0}}, lo[NIB]};
    sum     = {hi[HW-1:0], lo[NIB-1:0]};
    c_flag  = hi[HW] ^ sub;
    ac_flag = lo[NIB] ^ sub;
  end
endmodule

// File: rtl/alu8_szp.sv
module alu8_szp #(
  parameter int W = 8
) (
  input  logic [W-1:0] res,
  output logic         s,
  output logic         z,
  output logic         p
);
  always_comb begin
    s = res[W-1];
    z = (res == '0);
    p = ~(^res);
  end
endmodule

// File: rtl/alu8_wide.sv
module alu8_wide
  import alu8_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  wide_mode_e    mode,
  output logic [DW-1:0] sum,
  output logic          cout
);
  logic [DW-1:0] opd;
  logic [DW:0]   full;

  always_comb begin
    unique case (mode)
      WM_INC:  opd = {{(DW-1){1'b0}}, 1'b1};
      WM_DEC:  opd = '1;
      default: opd = b;
    endcase
    full = {1'b0, a} + {1'b0, opd};
    sum  = full[DW-1:0];
    cout = full[DW];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [3:0]      in_op,
  input  logic [2*W-1:0]  in_a,
  input  logic [2*W-1:0]  in_b,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2*W-1:0]  out_res,
  output logic [7:0]      flags_o
);
  localparam int DW = 2 * W;

  alu_op_e       op;
  logic [W-1:0]  a8, b8, as_sum, lg, byte_r;
  logic          is_sub, cin, as_c, as_ac, f_s, f_z, f_p, w_c, accept;
  logic [DW-1:0] w_sum, res_n;
  logic [7:0]    flg, flg_n;
  wide_mode_e    wmode;

  assign op       = alu_op_e'(in_op);
  assign a8       = in_a[W-1:0];
  assign b8       = in_b[W-1:0];
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign flags_o  = flg;

  assign is_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign cin    = ((op == OP_ADC) || (op == OP_SBB)) && flg[FB_C];

  alu8_addsub #(.W(W), .NIB(4)) u_addsub (
    .a(a8), .b(b8), .sub(is_sub), .cin(cin),
    .sum(as_sum), .c_flag(as_c), .ac_flag(as_ac)
  );

  always_comb begin
    unique case (op)
      OP_AND:  lg = a8 & b8;
      OP_XOR:  lg = a8 ^ b8;
      default: lg = a8 | b8;
    endcase
    byte_r = ((op == OP_AND) || (op == OP_XOR) || (op == OP_OR)) ? lg : as_sum;
    wmode  = (op == OP_WINC) ? WM_INC : (op == OP_WDEC) ? WM_DEC : WM_ADD;
  end

  alu8_szp #(.W(W)) u_szp (.res(byte_r), .s(f_s), .z(f_z), .p(f_p));

  alu8_wide #(.DW(DW)) u_wide (
    .a(in_a), .b(in_b), .mode(wmode), .sum(w_sum), .cout(w_c)
  );

  always_comb begin
    res_n = '0;
    flg_n = flg;
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        res_n = {{W{1'b0}}, as_sum};
        flg_n = pack_flags(f_s, f_z, as_ac, f_p, as_c);
      end
      OP_CMP: begin
        res_n = {{W{1'b0}}, a8};
        flg_n = pack_flags(f_s, f_z, as_ac, f_p, as_c);
      end
      OP_AND, OP_XOR, OP_OR: begin
        res_n = {{W{1'b0}}, lg};
        flg_n = pack_flags(f_s, f_z, 1'b0, f_p, 1'b0);
      end
      OP_STC: flg_n[FB_C] = 1'b1;
      OP_CMC: flg_n[FB_C] = ~flg[FB_C];
      OP_WADD: begin
        res_n = w_sum;
        flg_n[FB_C] = w_c;
      end
      OP_WINC, OP_WDEC: res_n = w_sum;
      OP_FWR: flg_n = (in_b[7:0] & ~FIX_MASK) | FIX_VAL;
      OP_FRD: res_n = {{(DW-8){1'b0}}, flg};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg       <= FIX_VAL;
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (accept) begin
      flg       <= flg_n;
      out_res   <= res_n;
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_res));

  a_r5_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[1] && !flags_o[3] && !flags_o[5]);

  a_r7_wide_keep: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (in_op == 4'd11 || in_op == 4'd12) |=> $stable(flags_o));

  a_r6_wadd_only_c: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 4'd10 |=> flags_o[7:1] == $past(flags_o[7:1]));

  a_r8_stc: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 4'd8 |=> flags_o[0] && flags_o[7:1] == $past(flags_o[7:1]));

  a_r9_frd_keep: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op == 4'd14 |=> $stable(flags_o) && out_res[7:0] == flags_o);
endmodule

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
module test_alu8_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = 4'd15;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_res;
  logic [7:0]  flags_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] mf;

  always #2.5 clk = ~clk;

  alu8_core i_alu8_core (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res), .flags_o(flags_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] mk(input logic [7:0] r, input logic ac, input logic c);
    logic [7:0] f;
    f = 8'h02;
    f[7] = r[7];
    f[6] = (r == 8'h00);
    f[4] = ac;
    f[2] = ~(^r);
    f[0] = c;
    return f;
  endfunction

  // bench model of one operation: returns {result, flags}
  function automatic logic [23:0] model(input logic [3:0] op, input logic [15:0] a,
                                        input logic [15:0] b, input logic [7:0] f);
    int t, lt, ci;
    logic [7:0] r, nf;
    logic [15:0] w;
    w = 16'h0; nf = f;
    ci = 0;
    case (op)
      4'd0, 4'd1: begin
        ci = (op == 4'd1) ? int'(f[0]) : 0;
        t  = int'(a[7:0]) + int'(b[7:0]) + ci;
        lt = int'(a[3:0]) + int'(b[3:0]) + ci;
        r  = t[7:0];
        nf = mk(r, lt > 15, t > 255);
        w  = {8'h00, r};
      end
      4'd2, 4'd3, 4'd7: begin
        ci = (op == 4'd3) ? int'(f[0]) : 0;
        t  = int'(a[7:0]) - int'(b[7:0]) - ci;
        lt = int'(a[3:0]) - int'(b[3:0]) - ci;
        r  = t[7:0];
        nf = mk(r, lt < 0, t < 0);
        w  = (op == 4'd7) ? {8'h00, a[7:0]} : {8'h00, r};
      end
      4'd4, 4'd5, 4'd6: begin
        r  = (op == 4'd4) ? (a[7:0] & b[7:0]) : (op == 4'd5) ? (a[7:0] ^ b[7:0]) : (a[7:0] | b[7:0]);
        nf = mk(r, 1'b0, 1'b0);
        w  = {8'h00, r};
      end
      4'd8:  nf[0] = 1'b1;
      4'd9:  nf[0] = ~f[0];
      4'd10: begin
        t = int'(a) + int'(b);
        w = t[15:0];
        nf[0] = (t > 65535);
      end
      4'd11: w = a + 16'd1;
      4'd12: w = a - 16'd1;
      4'd13: nf = (b[7:0] & 8'hD5) | 8'h02;
      4'd14: w = {8'h00, f};
      default: ;
    endcase
    return {w, nf};
  endfunction

  task automatic run_op(input string req, input logic [3:0] op,
                        input logic [15:0] a, input logic [15:0] b);
    logic [23:0] e;
    e = model(op, a, b, mf);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check({req, " result"}, {16'd0, out_res}, {16'd0, e[23:8]});
    check({req, " flags"}, {24'd0, flags_o}, {24'd0, e[7:0]});
    mf = e[7:0];
  endtask

  task automatic t_reset();
    check("R11 out_valid", {31'd0, out_valid}, 32'd0);
    check("R11 flags", {24'd0, flags_o}, 32'h02);
    check("R10 ready idle", {31'd0, in_ready}, 32'd1);
  endtask

  task automatic t_add();
    run_op("R1 add carry", 4'd0, 16'h003A, 16'h00C6);
    check("R3 R5 add flag byte", {24'd0, flags_o}, 32'h57);
    run_op("R1 add plain", 4'd0, 16'hFF12, 16'hAA21);
    run_op("R1 add halfcarry", 4'd0, 16'h0008, 16'h0008);
    run_op("R8 stc", 4'd8, 16'h0, 16'h0);
    run_op("R1 adc with carry", 4'd1, 16'h007F, 16'h0000);
    run_op("R3 adc sign", 4'd1, 16'h0080, 16'h007F);
  endtask

  task automatic t_sub();
    run_op("R2 sub borrow", 4'd2, 16'h0010, 16'h0001);
    run_op("R2 sub underflow", 4'd2, 16'h0003, 16'h0005);
    run_op("R2 sbb borrow in", 4'd3, 16'h0005, 16'h0005);
    run_op("R2 cmp equal", 4'd7, 16'h0042, 16'h0042);
    run_op("R2 cmp less", 4'd7, 16'h0020, 16'h0031);
  endtask

  task automatic t_logic();
    run_op("R8 stc", 4'd8, 16'h0, 16'h0);
    run_op("R4 and", 4'd4, 16'h00F0, 16'h0F3C);
    run_op("R8 stc", 4'd8, 16'h0, 16'h0);
    run_op("R4 xor zero", 4'd5, 16'h005A, 16'h005A);
    run_op("R4 or", 4'd6, 16'h0081, 16'h0002);
    for (int i = 0; i < 24; i++) begin
      logic [3:0] op;
      op = 4'(i % 8);
      run_op("R3 sweep", op, 16'(i * 37 + 11), 16'(i * 91 + 5));
    end
  endtask

  task automatic t_flag_ops();
    run_op("R9 fwr", 4'd13, 16'h0, 16'h00FF);
    check("R5 fixed bits after write", {24'd0, flags_o}, 32'hD7);
    run_op("R9 frd", 4'd14, 16'h0, 16'h0);
    run_op("R8 cmc", 4'd9, 16'h0, 16'h0);
    run_op("R8 cmc back", 4'd9, 16'h0, 16'h0);
    run_op("R9 fwr zero", 4'd13, 16'h0, 16'h0028);
    check("R5 forced bits", {24'd0, flags_o}, 32'h02);
    run_op("R8 stc lone", 4'd8, 16'h0, 16'h0);
    run_op("R9 nop", 4'd15, 16'h1234, 16'h5678);
  endtask

  task automatic t_wide();
    run_op("R9 fwr setup", 4'd13, 16'h0, 16'h00D4);
    run_op("R6 wadd carry", 4'd10, 16'hFF00, 16'h0180);
    run_op("R6 wadd nocarry", 4'd10, 16'h1234, 16'h1111);
    run_op("R6 wadd double", 4'd10, 16'h8001, 16'h8001);
    run_op("R7 winc wrap", 4'd11, 16'hFFFF, 16'h0);
    run_op("R7 wdec wrap", 4'd12, 16'h0000, 16'h0);
    run_op("R7 winc", 4'd11, 16'h00FF, 16'h0);
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 4'd0; in_a = 16'h0001; in_b = 16'h0002;
    @(negedge clk);
    in_op = 4'd2; in_a = 16'h0009; in_b = 16'h0001;
    check("R10 valid held", {31'd0, out_valid}, 32'd1);
    check("R10 ready low", {31'd0, in_ready}, 32'd0);
    check("R10 first result", {16'd0, out_res}, 32'h3);
    repeat (2) @(negedge clk);
    check("R10 stable result", {16'd0, out_res}, 32'h3);
    check("R10 still valid", {31'd0, out_valid}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second result", {16'd0, out_res}, 32'h8);
    check("R10 valid after", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R10 drained", {31'd0, out_valid}, 32'd0);
    mf = model(4'd2, 16'h9, 16'h1, model(4'd0, 16'h1, 16'h2, mf)[7:0])[7:0];
    check("R10 flags after", {24'd0, flags_o}, {24'd0, mf});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    mf = 8'h02;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_add();
    t_sub();
    t_logic();
    t_flag_ops();
    t_wide();
    t_backpressure();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule